// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block drives a bank of general-purpose pins from a narrow register bus. Three registers sit behind a 2-bit select: an output-level register, a direction register and a read-only sampled-pin register. Software can load a whole register with one write. It can also change individual bits with set and clear masks, which leave all other bits untouched. Writing ones to the sampled-pin register inverts the matching output-level bits, so a pin can be toggled in a single bus cycle.

Each pin produces three pad controls: output enable, output level and pull-up enable. A pin that is an input and has its output-level bit at 1 gets its pull-up, unless the global pull-up kill input is high. Each pin also has its own alternate-function override. When the override is on, a peripheral supplies that pin's output enable and output level. The override affects only the pin it belongs to. Pin levels pass through a reset-cleared synchroniser of `SYNC_STAGES` flops before they can be read.

The block has no sequencer. All behaviour comes from a next-state decode of the selected register plus per-pin combinational pad logic. Read data is combinational, gated by the read strobe.

Top module: `gpio_port`

## Requirements
- R1: After reset, the output-level and direction registers are all zero: every pin is an input, pad_oe and pad_pu are 0, and reading select 0 or 1 returns 0.
- R2: With wr_en=1, select 0 loads wdata into the output-level register and select 1 loads it into the direction register, effective from the next clock. With rd_en=1, select 0 and select 1 read those registers back.
- R3: With wr_en=0 and select 0 or 1, the selected register becomes (old | set_mask) & ~clr_mask at the next clock. A bit present in both masks ends up cleared. Bits in neither mask keep their value.
- R4: With wr_en=1 and select 2, each output-level bit whose wdata bit is 1 is inverted. Bits whose wdata bit is 0 are unchanged. The direction register is not affected.
- R5: With rd_en=1 and select 2, rdata returns pin_in as sampled SYNC_STAGES (default 2) rising edges earlier. The synchroniser clears to zero on reset.
- R6: pad_pu[n] is 1 exactly when direction bit n is 0, output-level bit n is 1 and pull_off is 0. This holds regardless of alt_en.
- R7: While pull_off is 1, pad_pu is all zeros.
- R8: When alt_en[n] is 0, pad_oe[n] equals direction bit n and pad_out[n] equals output-level bit n. When alt_en[n] is 1, they equal alt_oe[n] and alt_out[n]. Other pins are not affected.
- R9: With rd_en=0, rdata is 0. Reading select 3 returns 0. A write to select 3 changes no register.
- R10: The set and clear masks are ignored when wr_en=1, and also for select 2 and select 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 output level, 1 direction, 2 sampled pins, 3 unused |
| wr_en | input | 1 | Whole-register write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | WIDTH | Write data |
| set_mask | input | WIDTH | Bits to set when wr_en is low |
| clr_mask | input | WIDTH | Bits to clear when wr_en is low (clear wins over set) |
| rdata | output | WIDTH | Read data |
| pull_off | input | 1 | Global pull-up kill |
| pin_in | input | WIDTH | Raw pin levels from the pads |
| alt_en | input | WIDTH | Per-pin alternate-function override |
| alt_oe | input | WIDTH | Alternate output enable |
| alt_out | input | WIDTH | Alternate output level |
| pad_oe | output | WIDTH | Pad output enable |
| pad_out | output | WIDTH | Pad output level |
| pad_pu | output | WIDTH | Pad pull-up enable |

## Verification
The bench uses the defaults WIDTH=8 and SYNC_STAGES=2. A full byte lets every mask pattern appear, including overlapping set and clear bits and partial alternate overrides. A two-stage synchroniser keeps the pin read latency short enough that a random pin stream can be checked cycle by cycle against a two-deep history in the bench. With these values, all four select codes and the pull-up corner cases (pull_off, output direction, alternate override) come up many times in a few hundred cycles.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        SEL_LEVEL = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_PINS  = 2'd2,
        SEL_NONE  = 2'd3
    } gpio_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  gpio_sel_e        sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] set_mask,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] level_q,
    output logic [WIDTH-1:0] dir_q
);
    logic [WIDTH-1:0] level_d;
    logic [WIDTH-1:0] dir_d;

    always_comb begin
        level_d = level_q;
        dir_d   = dir_q;
        if (wr_en) begin
            unique case (sel)
                SEL_LEVEL: level_d = wdata;
                SEL_DIR:   dir_d   = wdata;
                SEL_PINS:  level_d = level_q ^ wdata;
                default:   ;
            endcase
        end else begin
            unique case (sel)
                SEL_LEVEL: level_d = (level_q | set_mask) & ~clr_mask;
                SEL_DIR:   dir_d   = (dir_q | set_mask) & ~clr_mask;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            dir_q   <= '0;
        end else begin
            level_q <= level_d;
            dir_q   <= dir_d;
        end
    end
endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] dir,
    input  logic             pull_off,
    input  logic [WIDTH-1:0] alt_en,
    input  logic [WIDTH-1:0] alt_oe,
    input  logic [WIDTH-1:0] alt_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);
    for (genvar n = 0; n < WIDTH; n++) begin : g_pin
        assign pad_oe[n]  = alt_en[n] ? alt_oe[n]  : dir[n];
        assign pad_out[n] = alt_en[n] ? alt_out[n] : level[n];
        assign pad_pu[n]  = ~dir[n] & level[n] & ~pull_off;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] set_mask,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] rdata,
    input  logic             pull_off,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] alt_en,
    input  logic [WIDTH-1:0] alt_oe,
    input  logic [WIDTH-1:0] alt_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);
    gpio_sel_e        sel;
    logic [WIDTH-1:0] level_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pins_s;

    assign sel = gpio_sel_e'(reg_sel);

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pins_s)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .level_q  (level_q),
        .dir_q    (dir_q)
    );

    gpio_padctl #(.WIDTH(WIDTH)) u_pad (
        .level    (level_q),
        .dir      (dir_q),
        .pull_off (pull_off),
        .alt_en   (alt_en),
        .alt_oe   (alt_oe),
        .alt_out  (alt_out),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out),
        .pad_pu   (pad_pu)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_LEVEL: rdata = level_q;
                SEL_DIR:   rdata = dir_q;
                SEL_PINS:  rdata = pins_s;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_sel,
    input logic             wr_en,
    input logic             rd_en,
    input logic [WIDTH-1:0] wdata,
    input logic [WIDTH-1:0] rdata,
    input logic             pull_off,
    input logic [WIDTH-1:0] pin_in,
    input logic [WIDTH-1:0] alt_en,
    input logic [WIDTH-1:0] alt_oe,
    input logic [WIDTH-1:0] alt_out,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_pu
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R5
    pin_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SYNC_STAGES == 2 && since_rst >= 2'd2 && rd_en && reg_sel == 2'd2)
            |-> rdata == $past(pin_in, 2));

    // R6
    pullup_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & ~alt_en & (pad_oe | ~pad_out)) == '0));

    // R7
    pull_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_off |-> pad_pu == '0);

    // R8
    alt_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe ^ alt_oe) | (pad_out ^ alt_out)) & alt_en) == '0);

    // R9
    unused_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || reg_sel == 2'd3) |-> rdata == '0);

    // R4
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd2 && alt_en == '0)
            |=> (alt_en != '0) || pad_out == $past(pad_out ^ wdata));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_sel  (reg_sel),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .pull_off (pull_off),
    .pin_in   (pin_in),
    .alt_en   (alt_en),
    .alt_oe   (alt_oe),
    .alt_out  (alt_out),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .pad_pu   (pad_pu)
);

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   reg_sel = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [W-1:0] wdata = '0, set_mask = '0, clr_mask = '0;
    logic [W-1:0] rdata;
    logic         pull_off = 1'b0;
    logic [W-1:0] pin_in = '0, alt_en = '0, alt_oe = '0, alt_out = '0;
    logic [W-1:0] pad_oe, pad_out, pad_pu;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // model state
    logic [W-1:0] m_level = '0, m_dir = '0, m_s1 = '0, m_s2 = '0;

    always #5 clk = ~clk;

    gpio_port #(.WIDTH(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .set_mask(set_mask), .clr_mask(clr_mask), .rdata(rdata),
        .pull_off(pull_off), .pin_in(pin_in), .alt_en(alt_en), .alt_oe(alt_oe),
        .alt_out(alt_out), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    function automatic logic [W-1:0] f_read(logic rd, logic [1:0] s);
        if (!rd) return '0;
        case (s)
            2'd0:    return m_level;
            2'd1:    return m_dir;
            2'd2:    return m_s2;
            default: return '0;
        endcase
    endfunction

    function automatic logic [W-1:0] f_pu(logic poff);
        return poff ? '0 : (~m_dir & m_level);
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, check before the edge, advance model at the edge
    task automatic cyc(logic [1:0] s, logic wr, logic rd, logic [W-1:0] wd,
                       logic [W-1:0] sm, logic [W-1:0] cm, logic [W-1:0] pin,
                       logic poff, logic [W-1:0] ae, logic [W-1:0] ao,
                       logic [W-1:0] av, string rtag);
        logic [W-1:0] nl, nd;
        string tg;
        @(negedge clk);
        reg_sel = s; wr_en = wr; rd_en = rd; wdata = wd; set_mask = sm;
        clr_mask = cm; pin_in = pin; pull_off = poff; alt_en = ae;
        alt_oe = ao; alt_out = av;
        #1;
        if (rtag != "")             tg = rtag;
        else if (!rd || s == 2'd3)  tg = "R9";
        else if (s == 2'd2)         tg = "R5";
        else                        tg = "R2";
        check(tg, rdata, f_read(rd, s));
        check(poff ? "R7" : "R6", pad_pu, f_pu(poff));
        check("R8", pad_oe, (ae & ao) | (~ae & m_dir));
        check("R8", pad_out, (ae & av) | (~ae & m_level));
        nl = m_level; nd = m_dir;
        if (wr) begin
            if (s == 2'd0) nl = wd;
            else if (s == 2'd1) nd = wd;
            else if (s == 2'd2) nl = m_level ^ wd;
        end else begin
            if (s == 2'd0) nl = (m_level | sm) & ~cm;
            else if (s == 2'd1) nd = (m_dir | sm) & ~cm;
        end
        @(posedge clk);
        m_level = nl; m_dir = nd; m_s2 = m_s1; m_s1 = pin;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cyc(2'd0, 0, 1, 8'h00, 8'h00, 8'h00, 8'h00, 0, 8'h00, 8'h00, 8'h00, "R1");
        check("R1", pad_oe, 8'h00);
        check("R1", pad_pu, 8'h00);
        cyc(2'd1, 0, 1, 8'h00, 8'h00, 8'h00, 8'h00, 0, 8'h00, 8'h00, 8'h00, "R1");
        // R2 whole writes
        cyc(2'd0, 1, 0, 8'hA5, 8'h00, 8'h00, 8'h00, 0, 8'h00, 8'h00, 8'h00, "");
        cyc(2'd1, 1, 0, 8'h0F, 8'h00, 8'h00, 8'h00, 0, 8'h00, 8'h00, 8'h00, "");
        cyc(2'd0, 0, 1, 8'h00, 8'h00, 8'h00, 8'h00, 0, 8'h00, 8'h00, 8'h00, "R2");
        check("R2", rdata, 8'hA5);
        // R3 set/clear with overlap: clear wins
        cyc(2'd0, 0, 0, 8'h00, 8'h1A, 8'h18, 8'h00, 0, 8'h00, 8'h00, 8'h00, "");
        cyc(2'd0, 0, 1, 8'h00, 8'h00, 8'h00, 8'h00, 0, 8'h00, 8'h00, 8'h00, "R3");
        check("R3", rdata, 8'hA7);
        // R10 masks ignored during a whole write and for select 2/3
        cyc(2'd1, 1, 0, 8'h33, 8'hC0, 8'h03, 8'h00, 0, 8'h00, 8'h00, 8'h00, "");
        cyc(2'd3, 0, 0, 8'h00, 8'hFF, 8'hFF, 8'h00, 0, 8'h00, 8'h00, 8'h00, "");
        cyc(2'd2, 0, 0, 8'h00, 8'hFF, 8'hFF, 8'h00, 0, 8'h00, 8'h00, 8'h00, "");
        cyc(2'd1, 0, 1, 8'h00, 8'h00, 8'h00, 8'h00, 0, 8'h00, 8'h00, 8'h00, "R10");
        check("R10", rdata, 8'h33);
        // R9 write to select 3 changes nothing
        cyc(2'd3, 1, 1, 8'hFF, 8'h00, 8'h00, 8'h00, 0, 8'h00, 8'h00, 8'h00, "R9");
        cyc(2'd0, 0, 1, 8'h00, 8'h00, 8'h00, 8'h00, 0, 8'h00, 8'h00, 8'h00, "R9");
        check("R9", rdata, 8'hA7);
        // R4 toggle via pin register
        cyc(2'd2, 1, 0, 8'h81, 8'h00, 8'h00, 8'h00, 0, 8'h00, 8'h00, 8'h00, "");
        cyc(2'd0, 0, 1, 8'h00, 8'h00, 8'h00, 8'h00, 0, 8'h00, 8'h00, 8'h00, "R4");
        check("R4", rdata, 8'h26);
        // R7 pull-up kill, R8 partial override
        cyc(2'd1, 1, 0, 8'h00, 8'h00, 8'h00, 8'h00, 1, 8'h0F, 8'h05, 8'h0A, "");
        check("R7", pad_pu, 8'h00);
        // R5 pin latency
        cyc(2'd2, 0, 1, 8'h00, 8'h00, 8'h00, 8'h5C, 0, 8'h00, 8'h00, 8'h00, "R5");
        cyc(2'd2, 0, 1, 8'h00, 8'h00, 8'h00, 8'h00, 0, 8'h00, 8'h00, 8'h00, "R5");
        cyc(2'd2, 0, 1, 8'h00, 8'h00, 8'h00, 8'h00, 0, 8'h00, 8'h00, 8'h00, "R5");
        check("R5", rdata, 8'h5C);
        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [W-1:0] sm, cm, ae;
            sm = ($urandom % 3 == 0) ? W'($urandom) : '0;
            cm = ($urandom % 3 == 0) ? W'($urandom) : '0;
            ae = ($urandom % 4 == 0) ? W'($urandom) : '0;
            cyc(2'($urandom), ($urandom % 3 == 0), ($urandom % 4 != 0), W'($urandom),
                sm, cm, W'($urandom), ($urandom % 5 == 0), ae, W'($urandom),
                W'($urandom), "");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule